// File: doc/BRIEF.md
# External Interrupt Line Controller

This block watches sixteen interrupt lines, each fed from a GPIO pin chosen by a per-line port selector, and turns armed edges on those lines into sticky pending flags. Each line can be armed for rising edges, falling edges or both. Software can also force a line pending, and it clears pending flags by writing ones. Two CPUs each own an interrupt-mask bank and an event-mask bank, so each CPU sees only the lines it has enabled.

Pending lines are folded into seven interrupt outputs per CPU. Lines 0 to 4 each have their own output. Lines 5 to 9 share one output, and lines 10 to 15 share another. Each CPU also gets an event output: a one-cycle pulse that fires when a fresh armed edge arrives on a line that CPU's event mask enables. All configuration goes through a small register-bus slave with single-cycle writes and reads that return one cycle later.

Top module: `eic_top`

## Requirements
- R1: After reset, every interrupt and event output is 0. Every register reads as 0, including the rising, falling, pending, both mask banks and the port selectors.
- R2: A line with its rising-arm bit set (bit n at offset 0x00) sets pending bit n after a 0-to-1 change on its selected pin. An input changed just before clock edge k is seen as pending after edge k+2.
- R3: A line with its falling-arm bit set (bit n at offset 0x04) sets pending on a 1-to-0 change. With both arm bits set, either change sets pending.
- R4: A change on a line whose arm bit for that direction is 0 leaves pending unchanged.
- R5: Writing a 1 to bit n at offset 0x08 sets pending bit n on that write's clock edge. Offset 0x08 always reads 0.
- R6: Writing a 1 to bit n of the pending register (offset 0x0C) clears it. Writing a 0 leaves the bit unchanged.
- R7: If a hardware edge and a write-one-clear reach the same pending bit on the same edge, the bit ends up set.
- R8: The CPU1 masks are interrupt mask 0x80 and event mask 0x84. The CPU2 masks are 0xC0 and 0xC4. A mask bit of 1 passes the line through. Interrupt output bit g (for g = 0 to 4) is pending[g] AND mask[g]. Bit 5 is the OR of that product over lines 5 to 9. Bit 6 is the OR over lines 10 to 15.
- R9: A CPU's event output pulses high for exactly one cycle, in the same cycle pending would first show the edge. It pulses for an armed edge on a line its event mask enables, whether or not that line is already pending. A software trigger does not produce an event.
- R10: Each line has a 4-bit source-port field. Line n's field sits in the register at 0x100 + 4*(n/4), at bit 4*(n%4). Field value p selects gpio_in[p*16+n]. A value of NUM_PORTS or above selects a constant 0, so pin changes on that line have no effect.
- R11: The writable registers read back their low 16 bits, and bits 31:16 read 0. An unmapped offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | High the cycle after a read strobe |
| gpio_in | input | NUM_PORTS*16 | GPIO pins; port p, pin n at bit p*16+n |
| cpu1_irq | output | 7 | CPU1 grouped interrupt outputs |
| cpu2_irq | output | 7 | CPU2 grouped interrupt outputs |
| cpu1_evt | output | 1 | CPU1 event pulse |
| cpu2_evt | output | 1 | CPU2 event pulse |

## Verification
The bench builds the block with NUM_PORTS = 3. This leaves selector values 3 to 15 unused, so the constant-zero source of an out-of-range selector can be driven and observed. Port 2 is a real, non-default source whose pins can be toggled while port 0's matching pins toggle and are ignored. Read values go to a scoreboard queue and are compared when the read data comes back. Event pulses and the set-versus-clear collision are checked in exact cycles.

// File: rtl/eic_pkg.sv
`timescale 1ns/1ps
package eic_pkg;
  localparam int unsigned LINES     = 16;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned PSEL_W    = 4;
  localparam int unsigned SEL_PER_R = 4;
  localparam int unsigned PSEL_REGS = LINES / SEL_PER_R;
  localparam int unsigned CPUS      = 2;
  localparam int unsigned SOLO      = 5;   // lines with a private output
  localparam int unsigned MID_LAST  = 9;   // last line of the middle group
  localparam int unsigned IRQS      = SOLO + 2;

  localparam int unsigned OFS_RISE  = 'h000;
  localparam int unsigned OFS_FALL  = 'h004;
  localparam int unsigned OFS_SOFT  = 'h008;
  localparam int unsigned OFS_PEND  = 'h00C;
  localparam int unsigned OFS_IMSK0 = 'h080;
  localparam int unsigned OFS_EMSK0 = 'h084;
  localparam int unsigned OFS_IMSK1 = 'h0C0;
  localparam int unsigned OFS_EMSK1 = 'h0C4;
  localparam int unsigned OFS_PSEL  = 'h100;
endpackage

// File: rtl/eic_regfile.sv
`timescale 1ns/1ps
module eic_regfile
  import eic_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_sel,
  input  logic                         bus_wr,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [DATA_W-1:0]            bus_wdata,
  output logic [DATA_W-1:0]            bus_rdata,
  output logic                         bus_rvalid,
  input  logic [LINES-1:0]             hw_set,
  output logic [LINES-1:0]             trig_rise,
  output logic [LINES-1:0]             trig_fall,
  output logic [LINES-1:0]             pend,
  output logic [CPUS-1:0][LINES-1:0]   imask,
  output logic [CPUS-1:0][LINES-1:0]   emask,
  output logic [LINES-1:0][PSEL_W-1:0] port_sel
);
  logic wr_en, rd_en;
  logic [LINES-1:0] lo;
  logic [LINES-1:0] rise_n, fall_n, pend_n, sw_set, clr;
  logic [CPUS-1:0][LINES-1:0] imask_n, emask_n;
  logic [LINES-1:0][PSEL_W-1:0] psel_n;
  logic [DATA_W-1:0] rd_n;

  assign wr_en = bus_sel & bus_wr;
  assign rd_en = bus_sel & ~bus_wr;
  assign lo    = bus_wdata[LINES-1:0];

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned ofs);
    return a == ADDR_W'(ofs);
  endfunction

  always_comb begin
    rise_n  = trig_rise;
    fall_n  = trig_fall;
    imask_n = imask;
    emask_n = emask;
    psel_n  = port_sel;
    sw_set  = '0;
    clr     = '0;
    if (wr_en) begin
      if (hit(bus_addr, OFS_RISE))  rise_n     = lo;
      if (hit(bus_addr, OFS_FALL))  fall_n     = lo;
      if (hit(bus_addr, OFS_SOFT))  sw_set     = lo;
      if (hit(bus_addr, OFS_PEND))  clr        = lo;
      if (hit(bus_addr, OFS_IMSK0)) imask_n[0] = lo;
      if (hit(bus_addr, OFS_EMSK0)) emask_n[0] = lo;
      if (hit(bus_addr, OFS_IMSK1)) imask_n[1] = lo;
      if (hit(bus_addr, OFS_EMSK1)) emask_n[1] = lo;
      for (int r = 0; r < PSEL_REGS; r++)
        if (hit(bus_addr, OFS_PSEL + 4*r)) psel_n[SEL_PER_R*r +: SEL_PER_R] = lo;
    end
    // hardware and software sets take priority over the write-one clear
    pend_n = (pend & ~clr) | hw_set | sw_set;
  end

  always_comb begin
    rd_n = '0;
    if (hit(bus_addr, OFS_RISE))  rd_n[LINES-1:0] = trig_rise;
    if (hit(bus_addr, OFS_FALL))  rd_n[LINES-1:0] = trig_fall;
    if (hit(bus_addr, OFS_PEND))  rd_n[LINES-1:0] = pend;
    if (hit(bus_addr, OFS_IMSK0)) rd_n[LINES-1:0] = imask[0];
    if (hit(bus_addr, OFS_EMSK0)) rd_n[LINES-1:0] = emask[0];
    if (hit(bus_addr, OFS_IMSK1)) rd_n[LINES-1:0] = imask[1];
    if (hit(bus_addr, OFS_EMSK1)) rd_n[LINES-1:0] = emask[1];
    for (int r = 0; r < PSEL_REGS; r++)
      if (hit(bus_addr, OFS_PSEL + 4*r)) rd_n[LINES-1:0] = port_sel[SEL_PER_R*r +: SEL_PER_R];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_rise  <= '0;
      trig_fall  <= '0;
      pend       <= '0;
      imask      <= '0;
      emask      <= '0;
      port_sel   <= '0;
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      trig_rise  <= rise_n;
      trig_fall  <= fall_n;
      pend       <= pend_n;
      imask      <= imask_n;
      emask      <= emask_n;
      port_sel   <= psel_n;
      bus_rvalid <= rd_en;
      if (rd_en) bus_rdata <= rd_n;
    end
  end

  assert_soft_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit(bus_addr, OFS_SOFT)) |=>
      ((pend & $past(lo)) == $past(lo)));

  assert_pend_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit(bus_addr, OFS_PEND) && ((lo & (hw_set | sw_set)) == '0)) |=>
      ((pend & $past(lo)) == '0));

  assert_pend_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr_en && (hit(bus_addr, OFS_PEND) || hit(bus_addr, OFS_SOFT))) && hw_set == '0) |=>
      (pend == $past(pend)));

  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set != '0) |=> ((pend & $past(hw_set)) == $past(hw_set)));
endmodule

// File: rtl/eic_edge_detect.sv
`timescale 1ns/1ps
module eic_edge_detect
  import eic_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_PORTS*LINES-1:0]   gpio_in,
  input  logic [LINES-1:0][PSEL_W-1:0] port_sel,
  input  logic [LINES-1:0]             trig_rise,
  input  logic [LINES-1:0]             trig_fall,
  output logic [LINES-1:0]             edge_hit
);
  logic [LINES-1:0] line_raw, sync_a, sync_b, sync_c;

  for (genvar n = 0; n < LINES; n++) begin : g_line
    logic pick;
    always_comb begin
      pick = 1'b0;
      for (int p = 0; p < NUM_PORTS; p++)
        if (port_sel[n] == PSEL_W'(p)) pick = gpio_in[p*LINES + n];
    end
    assign line_raw[n] = pick;

    assert_rise_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_b[n] && !sync_c[n]) |-> $past(line_raw[n], 2));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_a <= '0;
      sync_b <= '0;
      sync_c <= '0;
    end else begin
      sync_a <= line_raw;
      sync_b <= sync_a;
      sync_c <= sync_b;
    end
  end

  assign edge_hit = (sync_b & ~sync_c & trig_rise) | (~sync_b & sync_c & trig_fall);
endmodule

// File: rtl/eic_irq_combine.sv
`timescale 1ns/1ps
module eic_irq_combine
  import eic_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] pend,
  input  logic [LINES-1:0] mask,
  output logic [IRQS-1:0]  irq
);
  logic [LINES-1:0] live;
  assign live = pend & mask;

  for (genvar g = 0; g < SOLO; g++) begin : g_solo
    assign irq[g] = live[g];
  end
  assign irq[SOLO]   = |live[MID_LAST:SOLO];
  assign irq[SOLO+1] = |live[LINES-1:MID_LAST+1];

  assert_irq_needs_live_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq != '0) |-> ((pend & mask) != '0));
  assert_live_raises_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & mask) != '0) |-> (irq != '0));
endmodule

// File: rtl/eic_top.sv
`timescale 1ns/1ps
module eic_top
  import eic_pkg::*;
#(
  parameter int unsigned NUM_PORTS = 4,
  parameter int unsigned ADDR_W    = 12
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_sel,
  input  logic                       bus_wr,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [31:0]                bus_wdata,
  output logic [31:0]                bus_rdata,
  output logic                       bus_rvalid,
  input  logic [NUM_PORTS*16-1:0]    gpio_in,
  output logic [6:0]                 cpu1_irq,
  output logic [6:0]                 cpu2_irq,
  output logic                       cpu1_evt,
  output logic                       cpu2_evt
);
  logic [LINES-1:0]             trig_rise, trig_fall, pend, edge_hit;
  logic [CPUS-1:0][LINES-1:0]   imask, emask;
  logic [LINES-1:0][PSEL_W-1:0] port_sel;
  logic [CPUS-1:0][IRQS-1:0]    irq;
  logic [CPUS-1:0]              evt_n, evt_q;

  eic_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .hw_set(edge_hit), .trig_rise(trig_rise),
    .trig_fall(trig_fall), .pend(pend), .imask(imask), .emask(emask),
    .port_sel(port_sel)
  );

  eic_edge_detect #(.NUM_PORTS(NUM_PORTS)) u_edges (
    .clk(clk), .rst_n(rst_n), .gpio_in(gpio_in), .port_sel(port_sel),
    .trig_rise(trig_rise), .trig_fall(trig_fall), .edge_hit(edge_hit)
  );

  for (genvar c = 0; c < CPUS; c++) begin : g_cpu
    eic_irq_combine u_comb (
      .clk(clk), .rst_n(rst_n), .pend(pend), .mask(imask[c]), .irq(irq[c])
    );
    assign evt_n[c] = |(edge_hit & emask[c]);

    assert_evt_from_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
      evt_q[c] |-> ($past(edge_hit) != '0));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= evt_n;
  end

  assign cpu1_irq = irq[0];
  assign cpu2_irq = irq[1];
  assign cpu1_evt = evt_q[0];
  assign cpu2_evt = evt_q[1];
endmodule

// File: tb/eic_top_tb.sv
`timescale 1ns/1ps
module eic_top_tb;
  localparam int NP = 3;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic bus_rvalid;
  logic [NP*16-1:0] gpio = '0;
  logic [6:0] cpu1_irq, cpu2_irq;
  logic cpu1_evt, cpu2_evt;

  always #2 clk = ~clk;

  eic_top #(.NUM_PORTS(NP), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .gpio_in(gpio), .cpu1_irq(cpu1_irq),
    .cpu2_irq(cpu2_irq), .cpu1_evt(cpu1_evt), .cpu2_evt(cpu2_evt)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  typedef struct { logic [31:0] v; string tag; } exp_t;
  exp_t sbq[$];
  exp_t mon_e;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compares each returned read with the queued expectation
  always @(negedge clk) begin
    if (rst_n && bus_rvalid) begin
      if (sbq.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL scoreboard: unexpected read data %h expected none", bus_rdata);
      end else begin
        mon_e = sbq.pop_front();
        chk(mon_e.tag, bus_rdata, mon_e.v);
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, input logic [31:0] e, input string tag);
    exp_t x;
    @(negedge clk);
    x.v = e; x.tag = tag;
    sbq.push_back(x);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = AW'(a);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(4 * 100000);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    idle(3);
    chk("R1 irq1 in reset", {25'b0, cpu1_irq}, 0);
    @(negedge clk); rst_n = 1'b1;
    idle(2);
    chk("R1 irq2 after reset", {25'b0, cpu2_irq}, 0);
    chk("R1 evt after reset", {30'b0, cpu1_evt, cpu2_evt}, 0);
    rd('h000, 0, "R1 rise reset");
    rd('h00C, 0, "R1 pend reset");
    rd('h0C4, 0, "R1 emask2 reset");
    rd('h104, 0, "R1 psel reset");

    // R11 readback, upper half zero, unmapped zero; R5 soft reads 0
    wr('h000, 32'hFFFF_1234); rd('h000, 32'h1234, "R11 rise readback");
    wr('h004, 32'h0000_5678); rd('h004, 32'h5678, "R11 fall readback");
    wr('h080, 32'h0000_1111); rd('h080, 32'h1111, "R11 imask1 readback");
    wr('h084, 32'h0000_2222); rd('h084, 32'h2222, "R11 emask1 readback");
    wr('h0C0, 32'h0000_4444); rd('h0C0, 32'h4444, "R11 imask2 readback");
    wr('h0C4, 32'hABCD_8888); rd('h0C4, 32'h8888, "R11 emask2 readback");
    rd('h040, 0, "R11 unmapped");
    rd('h008, 0, "R5 soft reads zero");
    wr('h000, 0); wr('h004, 0); wr('h080, 0); wr('h084, 0); wr('h0C0, 0); wr('h0C4, 0);
    wr('h00C, 32'hFFFF);
    rd('h00C, 0, "R11 pend idle");

    // R2 rising on line 3 (port 0 by default)
    wr('h000, 32'h0008);
    gpio[3] = 1'b1; idle(4);
    rd('h00C, 32'h0008, "R2 rise sets pend");
    wr('h00C, 32'h0008);
    gpio[3] = 1'b0; idle(4);
    rd('h00C, 0, "R4 unarmed fall ignored");
    gpio[5] = 1'b1; idle(4);
    rd('h00C, 0, "R4 unarmed line ignored");

    // R3 both edges on line 4
    wr('h000, 32'h0010); wr('h004, 32'h0010);
    gpio[4] = 1'b1; idle(4);
    rd('h00C, 32'h0010, "R3 both rise");
    wr('h00C, 32'h0010);
    gpio[4] = 1'b0; idle(4);
    rd('h00C, 32'h0010, "R3 both fall");
    wr('h00C, 32'h0010); wr('h000, 0); wr('h004, 0);

    // R5 / R6
    wr('h008, 32'h8001); rd('h00C, 32'h8001, "R5 soft set");
    wr('h00C, 32'h0000); rd('h00C, 32'h8001, "R6 write zero no effect");
    wr('h00C, 32'h0001); rd('h00C, 32'h8000, "R6 clear one bit");
    wr('h00C, 32'h8000); rd('h00C, 0, "R6 clear rest");

    // R8 grouping and masks
    wr('h080, 32'h0421); wr('h0C0, 32'h0002);
    wr('h008, 32'h0001);
    chk("R8 solo line 0 cpu1", {25'b0, cpu1_irq}, 32'h01);
    chk("R8 cpu2 masked", {25'b0, cpu2_irq}, 0);
    wr('h008, 32'h0040);
    chk("R8 line 6 masked", {25'b0, cpu1_irq}, 32'h01);
    wr('h080, 32'h0461);
    chk("R8 group 5-9", {25'b0, cpu1_irq}, 32'h21);
    wr('h008, 32'h1002);
    chk("R8 cpu2 line 1", {25'b0, cpu2_irq}, 32'h02);
    wr('h080, 32'h1461);
    chk("R8 group 10-15", {25'b0, cpu1_irq}, 32'h61);
    wr('h00C, 32'hFFFF);
    chk("R8 cleared cpu1", {25'b0, cpu1_irq}, 0);
    chk("R8 cleared cpu2", {25'b0, cpu2_irq}, 0);
    wr('h080, 0); wr('h0C0, 0);

    // R9 event pulse timing on line 8
    wr('h084, 32'h0100); wr('h000, 32'h0100);
    gpio[8] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R9 evt not early", {31'b0, cpu1_evt}, 0);
    @(negedge clk);
    chk("R9 evt pulse", {31'b0, cpu1_evt}, 1);
    chk("R9 cpu2 evt masked", {31'b0, cpu2_evt}, 0);
    @(negedge clk);
    chk("R9 evt one cycle", {31'b0, cpu1_evt}, 0);
    gpio[8] = 1'b0; idle(4);
    gpio[8] = 1'b1;
    idle(3);
    chk("R9 evt while pending", {31'b0, cpu1_evt}, 1);
    idle(2);
    wr('h008, 32'h0100);
    chk("R9 soft no evt", {31'b0, cpu1_evt}, 0);
    idle(1);
    chk("R9 soft no evt later", {31'b0, cpu1_evt}, 0);
    gpio[8] = 1'b0; wr('h084, 0); idle(4);
    wr('h00C, 32'hFFFF);

    // R10 port select: line 8 from port 2, line 13 out of range
    wr('h108, 32'h0002); rd('h108, 32'h0002, "R10 psel readback");
    idle(4); wr('h00C, 32'hFFFF);
    gpio[8] = 1'b1; idle(4);
    rd('h00C, 0, "R10 deselected port ignored");
    gpio[40] = 1'b1; idle(4);
    rd('h00C, 32'h0100, "R10 port 2 drives line 8");
    gpio[40] = 1'b0; wr('h10C, 32'h0030);
    wr('h000, 32'h2100); idle(4); wr('h00C, 32'hFFFF);
    gpio[13] = 1'b1; gpio[29] = 1'b1; gpio[45] = 1'b1; idle(4);
    rd('h00C, 0, "R10 out of range select is zero");

    // R7 set beats clear on the same edge
    wr('h008, 32'h0001);
    gpio[40] = 1'b1;
    @(negedge clk);
    wr('h00C, 32'h0101);
    rd('h00C, 32'h0100, "R7 set wins over clear");

    idle(4);
    if (sbq.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL scoreboard: got %0d reads outstanding expected 0", sbq.size());
    end
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule